// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a clocked host read and write an asynchronous static RAM of 64K words by 16 bits. The RAM has active-low controls: chip select, write, output enable and one select per byte lane. The host places a single request on a valid/ready handshake. The request carries a word address, write data, a two-bit lane mask and a read/write flag. When a read completes, the block returns the read data together with a one-cycle done pulse. Writes also end with a done pulse.

On the memory side the block drives the address, the five strobes and a data-bus driver. The bus driver is a split output/enable/input trio that feeds a bidirectional pad. Every strobe comes straight from a flop. Each phase lasts a whole number of clock cycles, and that number is derived from the RAM's nanosecond limits and the clock period. When no request is in progress, every strobe is parked high. This keeps the RAM deselected, with its outputs floating and its supply current at the standby level.

The write strobe falls in the same cycle as the chip select and the lane selects, never later, so the RAM never turns its outputs on during a write. The controller does not drive the bus until output enable has been high long enough for the RAM's output drivers to let go. It keeps driving for one cycle after the write strobe rises, which gives the data hold time.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While `req_ready` is high, all five strobes are high and `mem_dq_oe` is low. After reset the block is in this state, with `req_ready` high and `rsp_done` low.
- R2: Lane mask bit 0 selects the lower byte (data bits 7:0) through `mem_lo_n`, and bit 1 selects the upper byte (bits 15:8) through `mem_hi_n`. During an access, a lane strobe goes low only for a selected lane. `mem_cs_n` is low exactly while at least one lane strobe is low.
- R3: `mem_we_n` falls in the same cycle as `mem_cs_n`, never after it. While `mem_we_n` is low, `mem_oe_n` is high and `mem_dq_oe` is high.
- R4: A write with a non-empty mask holds `mem_we_n` low for exactly `WP_CYC` cycles. During that time the address and the driven data stay stable.
- R5: `mem_dq_oe` stays high for exactly one cycle after `mem_we_n` rises and is low in the cycle after that. For a write with a non-empty mask, the driver is on for `WP_CYC`+1 cycles in total.
- R6: `mem_dq_oe` rises only after `mem_oe_n` has been high for at least `TURN_CYC` cycles.
- R7: A read with a non-empty mask holds `mem_cs_n`, `mem_oe_n` and the selected lane strobes low for exactly `ACC_CYC` cycles. `mem_we_n` stays high throughout. The bus is sampled at the clock edge that ends the last of those cycles.
- R8: `rsp_rdata` holds the sampled bytes of the selected lanes. Every unselected lane reads as zero.
- R9: Every request produces exactly one single-cycle `rsp_done` pulse. For a read, the pulse comes `ACC_CYC`+1 cycles after the accepting edge. For a write, the pulse comes in the cycle in which the driver is held.
- R10: A request with an empty lane mask (00) asserts no strobe and never drives the bus. It still completes with a done pulse, and if it is a read it returns zero.
- R11: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a request is in progress. `mem_addr` does not change while `mem_cs_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 2*LANE_W | Write data |
| req_lanes | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 2*LANE_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | RAM address |
| mem_dq_o | output | 2*LANE_W | Data toward the RAM pad |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_i | input | 2*LANE_W | Data from the RAM pad |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lo_n | output | 1 | Lower byte lane select, active low |
| mem_hi_n | output | 1 | Upper byte lane select, active low |

## Verification
The bench connects the controller to a behavioral RAM model. The model commits data only when the write strobes end, and it returns garbage on any lane that is unselected or whose access is shorter than the access time. A controller that sampled one cycle too early, or that forgot to clear an unselected lane, would therefore return wrong read data. Reads placed directly before writes check bus turnaround: if the driver turned on before output enable had been high for the required count, the bench would flag contention. Empty lane masks check that no strobe fires. A design that pulsed chip select anyway, or that drove the bus, would change nothing in memory but would show up in the strobe counts. Byte writes that alternate between lanes, followed by reads with every mask, expose a swapped or stuck lane decode as corrupted bytes.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WTURN = 3'd1,
    ST_WSTRB = 3'd2,
    ST_WHOLD = 3'd3,
    ST_RACC  = 3'd4
  } ctl_state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic lo_n;
    logic hi_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_PARK = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                      lo_n: 1'b1, hi_n: 1'b1, dq_oe: 1'b0};

  // whole clock cycles that cover a nanosecond limit
  function automatic int ns_to_cycles(int ns, int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // strobe levels for the state about to be entered
  function automatic strobe_t strobes_for(ctl_state_e st, logic [1:0] lanes);
    strobe_t s;
    logic    any;
    s   = STROBE_PARK;
    any = |lanes;
    case (st)
      ST_WSTRB: begin
        s.cs_n  = ~any;
        s.we_n  = ~any;
        s.lo_n  = ~lanes[0];
        s.hi_n  = ~lanes[1];
        s.dq_oe = any;
      end
      ST_WHOLD: s.dq_oe = any;
      ST_RACC: begin
        s.cs_n = ~any;
        s.oe_n = ~any;
        s.lo_n = ~lanes[0];
        s.hi_n = ~lanes[1];
      end
      default: s = STROBE_PARK;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_turn_guard.sv
module sram_turn_guard #(
  parameter int TURN_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  output logic quiet
);
  localparam int            TW  = $clog2(TURN_CYC + 2);
  localparam logic [TW-1:0] TOP = TW'(TURN_CYC);

  logic [TW-1:0] cnt_q;

  // cycles since output enable was last low, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= TOP;
    else if (!oe_n)      cnt_q <= '0;
    else if (cnt_q != TOP) cnt_q <= cnt_q + TW'(1);
  end

  assign quiet = (cnt_q == TOP);
endmodule

// File: rtl/sram_lane_mux.sv
module sram_lane_mux #(
  parameter int LANE_W = 8
) (
  input  logic [1:0]          lanes,
  input  logic [2*LANE_W-1:0] raw,
  output logic [2*LANE_W-1:0] kept
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign kept[g*LANE_W +: LANE_W] = lanes[g] ? raw[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LANE_W   = 8,
  parameter int CLK_NS   = 20,
  parameter int ACC_CYC  = ns_to_cycles(100, CLK_NS),
  parameter int WP_CYC   = max2(ns_to_cycles(85, CLK_NS), ns_to_cycles(50, CLK_NS)),
  parameter int TURN_CYC = ns_to_cycles(35, CLK_NS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  input  logic [1:0]          req_lanes,
  output logic                rsp_done,
  output logic [2*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*LANE_W-1:0] mem_dq_o,
  output logic                mem_dq_oe,
  input  logic [2*LANE_W-1:0] mem_dq_i,
  output logic                mem_cs_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic                mem_lo_n,
  output logic                mem_hi_n
);
  localparam int               DATA_W  = 2 * LANE_W;
  localparam int               CNT_W   = $clog2(max2(ACC_CYC, WP_CYC) + 1);
  localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);

  ctl_state_e          state_q, state_d;
  strobe_t             strb_q, strb_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q, rd_kept;
  logic [1:0]          lanes_q, lanes_d;
  logic                done_q;
  logic                accept, timer_load, expired, quiet;
  logic [CNT_W-1:0]    timer_val;

  // named events, also observed by the checker
  logic acc_end, wr_end;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready & req_valid;
  assign acc_end   = (state_q == ST_RACC)  & expired;
  assign wr_end    = (state_q == ST_WSTRB) & expired;
  assign lanes_d   = accept ? req_lanes : lanes_q;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val), .expired(expired)
  );

  sram_turn_guard #(.TURN_CYC(TURN_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .oe_n(strb_q.oe_n), .quiet(quiet)
  );

  sram_lane_mux #(.LANE_W(LANE_W)) u_mux (
    .lanes(lanes_q), .raw(mem_dq_i), .kept(rd_kept)
  );

  always_comb begin
    state_d    = state_q;
    timer_load = 1'b0;
    timer_val  = WP_LD;
    case (state_q)
      ST_IDLE: if (accept) begin
        if (req_write) state_d = ST_WTURN;
        else begin
          state_d    = ST_RACC;
          timer_load = 1'b1;
          timer_val  = ACC_LD;
        end
      end
      ST_WTURN: if (quiet) begin
        state_d    = ST_WSTRB;
        timer_load = 1'b1;
        timer_val  = WP_LD;
      end
      ST_WSTRB: if (expired) state_d = ST_WHOLD;
      ST_WHOLD: state_d = ST_IDLE;
      ST_RACC:  if (expired) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    strb_d = strobes_for(state_d, lanes_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      strb_q  <= STROBE_PARK;
      addr_q  <= '0;
      wdata_q <= '0;
      lanes_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      strb_q  <= strb_d;
      lanes_q <= lanes_d;
      done_q  <= acc_end | wr_end;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (acc_end) rdata_q <= rd_kept;
    end
  end

  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = strb_q.dq_oe;
  assign mem_cs_n  = strb_q.cs_n;
  assign mem_we_n  = strb_q.we_n;
  assign mem_oe_n  = strb_q.oe_n;
  assign mem_lo_n  = strb_q.lo_n;
  assign mem_hi_n  = strb_q.hi_n;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W   = 16,
  parameter int TURN_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              acc_end,
  input logic              wr_end,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lo_n,
  input logic              mem_hi_n,
  input logic              mem_dq_oe
);
  logic [7:0] oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          oe_hi_cnt <= 8'hFF;
    else if (!mem_oe_n)                  oe_hi_cnt <= 8'd0;
    else if (oe_hi_cnt != 8'hFF)         oe_hi_cnt <= oe_hi_cnt + 8'd1;
  end

  assert_parked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && mem_lo_n && mem_hi_n && !mem_dq_oe));

  assert_lane_implies_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_lo_n || !mem_hi_n) |-> !mem_cs_n);

  assert_cs_implies_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (!mem_lo_n || !mem_hi_n));

  assert_we_not_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_cs_n));

  assert_oe_off_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe));

  assert_hold_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dq_oe);

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= 8'(TURN_CYC)));

  assert_read_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n));

  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_end || wr_end) |=> rsp_done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .TURN_CYC(TURN_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .acc_end(acc_end), .wr_end(wr_end), .mem_addr(mem_addr),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;
  localparam int AW     = 8;
  localparam int DW     = 16;
  localparam int CLK_NS = 20;
  localparam int ACC_E  = (100 + CLK_NS - 1) / CLK_NS;
  localparam int WP_A   = (85 + CLK_NS - 1) / CLK_NS;
  localparam int WP_B   = (50 + CLK_NS - 1) / CLK_NS;
  localparam int WP_E   = (WP_A > WP_B) ? WP_A : WP_B;
  localparam int TURN_E = (35 + CLK_NS - 1) / CLK_NS;
  localparam logic [7:0] JUNK_LO = 8'hA5;
  localparam logic [7:0] JUNK_HI = 8'hC3;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_lanes = '0;
  logic          req_ready, rsp_done;
  logic [DW-1:0] rsp_rdata, mem_dq_o;
  logic [DW-1:0] mem_dq_i = {JUNK_HI, JUNK_LO};
  logic [AW-1:0] mem_addr;
  logic          mem_dq_oe, mem_cs_n, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n;

  sram_lane_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_lanes(req_lanes), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] ram [256];
  logic [DW-1:0] shadow [256];

  // RAM model and strobe monitor
  int oe_hi = 100, wr_cyc = 0, rd_cyc = 0, dq_cyc = 0, cs_cyc = 0, rcnt = 0;
  int err_park = 0, err_order = 0, err_turn = 0, err_hold = 0;
  logic lo_seen = 1'b0, hi_seen = 1'b0;
  logic prev_wa = 1'b0, prev_lo = 1'b0, prev_hi = 1'b0;
  logic prev_we_n = 1'b1, prev_cs_n = 1'b1, prev_dq_oe = 1'b0;
  logic [DW-1:0] prev_d = '0;
  logic [AW-1:0] prev_a = '0;

  always @(negedge clk) if (rst_n) begin
    logic wa, ra;
    wa = !mem_cs_n && !mem_we_n && (!mem_lo_n || !mem_hi_n);
    ra = !mem_cs_n && mem_we_n && !mem_oe_n && (!mem_lo_n || !mem_hi_n);
    if (req_ready && (!mem_cs_n || !mem_we_n || !mem_oe_n || !mem_lo_n || !mem_hi_n || mem_dq_oe))
      err_park++;
    if (!mem_we_n && (!mem_oe_n || !mem_dq_oe)) err_order++;
    if (!mem_we_n && prev_we_n && !prev_cs_n) err_order++;
    if (mem_dq_oe && !prev_dq_oe && oe_hi < TURN_E + 1) err_turn++;
    if (wa && prev_wa && (mem_dq_o != prev_d)) err_hold++;
    if (!mem_cs_n && !prev_cs_n && (mem_addr != prev_a)) err_hold++;
    if (!mem_we_n) wr_cyc++;
    if (ra) rd_cyc++;
    if (mem_dq_oe) dq_cyc++;
    if (!mem_cs_n) begin
      cs_cyc++;
      lo_seen = lo_seen | !mem_lo_n;
      hi_seen = hi_seen | !mem_hi_n;
    end
    if (prev_wa && !wa) begin
      if (prev_lo) ram[prev_a][7:0]  = prev_d[7:0];
      if (prev_hi) ram[prev_a][15:8] = prev_d[15:8];
    end
    rcnt = ra ? rcnt + 1 : 0;
    mem_dq_i = {(ra && !mem_hi_n && rcnt >= ACC_E) ? ram[mem_addr][15:8] : JUNK_HI,
                (ra && !mem_lo_n && rcnt >= ACC_E) ? ram[mem_addr][7:0]  : JUNK_LO};
    oe_hi      = mem_oe_n ? oe_hi + 1 : 0;
    prev_wa    = wa;
    prev_lo    = !mem_lo_n;
    prev_hi    = !mem_hi_n;
    prev_d     = mem_dq_o;
    prev_a     = mem_addr;
    prev_we_n  = mem_we_n;
    prev_cs_n  = mem_cs_n;
    prev_dq_oe = mem_dq_oe;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'((a * 40503 + k * 7919) ^ 15450);
  endfunction

  task automatic do_req(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] ln, output logic [DW-1:0] rd, output int lat);
    while (!req_ready) begin @(negedge clk); #1; end
    wr_cyc = 0; rd_cyc = 0; dq_cyc = 0; cs_cyc = 0; lo_seen = 1'b0; hi_seen = 1'b0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = ln;
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 0;
    do begin @(negedge clk); #1; lat++; end while (!rsp_done && lat < 100);
    rd = rsp_rdata;
  endtask

  task automatic wr_op(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] ln);
    logic [DW-1:0] rd;
    int lat;
    do_req(1'b1, a, d, ln, rd, lat);
    if (ln[0]) shadow[a][7:0]  = d[7:0];
    if (ln[1]) shadow[a][15:8] = d[15:8];
    chk(lat < 100, "R9 write done pulse", lat, WP_E + 2);
    chk(wr_cyc == ((ln != 0) ? WP_E : 0), "R4 write pulse cycles", wr_cyc, (ln != 0) ? WP_E : 0);
    chk(dq_cyc == ((ln != 0) ? WP_E + 1 : 0), "R5 driver cycles", dq_cyc, (ln != 0) ? WP_E + 1 : 0);
    chk({hi_seen, lo_seen} == ln, "R2 write lanes", {hi_seen, lo_seen}, ln);
    if (ln == 2'b00) chk(cs_cyc == 0, "R10 empty write no select", cs_cyc, 0);
  endtask

  task automatic rd_op(input logic [AW-1:0] a, input logic [1:0] ln);
    logic [DW-1:0] rd, ex;
    int lat;
    do_req(1'b0, a, '0, ln, rd, lat);
    ex = {ln[1] ? shadow[a][15:8] : 8'h00, ln[0] ? shadow[a][7:0] : 8'h00};
    chk(rd == ex, "R8 read data", rd, ex);
    chk(lat == ACC_E + 1, "R9 read latency", lat, ACC_E + 1);
    chk(rd_cyc == ((ln != 0) ? ACC_E : 0), "R7 read access cycles", rd_cyc, (ln != 0) ? ACC_E : 0);
    chk({hi_seen, lo_seen} == ln, "R2 read lanes", {hi_seen, lo_seen}, ln);
    if (ln == 2'b00) begin
      chk(cs_cyc == 0, "R10 empty read no select", cs_cyc, 0);
      chk(rd == '0, "R10 empty read zero", rd, 0);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 R11 reset state
    chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
    chk(rsp_done == 1'b0, "R1 no done after reset", rsp_done, 0);
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n, mem_dq_oe} == 6'b111110,
        "R1 parked strobes after reset",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n, mem_dq_oe}, 6'b111110);

    for (int a = 0; a < 256; a++) wr_op(AW'(a), pat(a, 1), 2'b11);
    for (int a = 0; a < 256; a++) wr_op(AW'(a), pat(a, 2), 2'(a % 3));
    for (int a = 0; a < 256; a++) rd_op(AW'(a), 2'(3 - (a % 4)));
    // read immediately followed by write exercises turnaround (R6)
    for (int a = 0; a < 64; a++) begin
      rd_op(AW'(a), 2'b11);
      wr_op(AW'(a), pat(a, 3), 2'(1 + (a % 3)));
      rd_op(AW'(a), 2'(a % 4));
    end

    chk(err_park == 0, "R1 parked while idle", err_park, 0);
    chk(err_order == 0, "R3 write strobe order", err_order, 0);
    chk(err_turn == 0, "R6 bus turnaround", err_turn, 0);
    chk(err_hold == 0, "R11 address and data stable", err_hold, 0);
    summary();
    $finish;
  end
endmodule